// File: doc/BRIEF.md
# Transmit Error Abort and Flush Controller

This block watches one frame at a time for a half-duplex Ethernet transmit engine and decides how each transmission ends. It starts an attempt when a frame's first descriptor is waiting. While the frame is on the wire it counts bit times from the first preamble bit. It stops the frame on one of three faults: the transmit FIFO running dry, a collision after the slot boundary, or a collision on the final permitted attempt.

A collision inside the slot on an earlier attempt produces a retry request instead. The controller then waits for an external backoff timer before it starts the attempt again. When the data path runs dry, the controller takes over the serial output for 32 bit times. It sends the bitwise complement of the running CRC, so the frame can never pass a receiver's check.

Every frame ends by closing all of its descriptors, one per cycle, through the end-of-frame marker. Each close carries a completion code. The controller then picks up the next frame with no software involvement. Three sticky event bits and a mask register drive a level interrupt.

Top module: `tx_err_ctl`

## Requirements
- R1: In the idle state, `tx_go_o` pulses combinationally in any cycle where `desc_valid_i` is high. It stays low while no descriptor is offered.
- R2: After `frame_end_i` during transmission, the frame's descriptors are closed one per cycle. Each close raises `desc_done_o` with `desc_stat_o` = 0 (success), up to and including the one marked by `desc_last_i`.
- R3: An underrun (`underrun_i` high during transmission) starts a 32-bit forced tail. `force_en_o` is high throughout. `force_bit_o` carries the complement of the `crc_i` value captured at the underrun, least significant bit first, advancing on each `bit_tick_i`. `tx_stop_o` pulses in the cycle of the 32nd tick.
- R4: An underrun closes every descriptor of the frame with status 1 and sets event bit 0.
- R5: A collision seen before 512 counted bit times on attempts 1 to 15 pulses `retry_o` without `tx_stop_o`. No event is set. The next attempt starts with `tx_go_o` only in the cycle `backoff_done_i` is high.
- R6: A collision before the slot boundary on the 16th attempt pulses `tx_stop_o` and not `retry_o`. It sets event bit 1 and closes the frame's descriptors with status 2.
- R7: A collision after at least 512 bit ticks of the current attempt is late. It pulses `tx_stop_o` and never `retry_o`, on any attempt, sets event bit 2, and closes the frame's descriptors with status 3.
- R8: The bit-time count restarts at each attempt, so ticks from earlier attempts never make a later collision late.
- R9: Once the last descriptor of a frame is closed, a waiting next descriptor gets `tx_go_o` in the very next cycle.
- R10: Event bits are sticky. They clear only through a write with `reg_sel_i` = 0, where each 1 in `reg_wdata_i` clears that bit. A set in the same cycle as a clear wins.
- R11: `irq_o` is high exactly when some event bit is set and its mask bit is 1. The mask is written with `reg_sel_i` = 1 and resets to 0.
- R12: During transmission a collision takes priority over an underrun in the same cycle. Collisions are ignored while the forced tail is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | 1 | A descriptor is at the head of the completion stream |
| desc_last_i | input | 1 | The head descriptor ends its frame |
| desc_done_o | output | 1 | Head descriptor closed and consumed this cycle |
| desc_stat_o | output | 2 | Completion code: 0 ok, 1 underrun, 2 retry limit, 3 late collision |
| bit_tick_i | input | 1 | One bit time elapsed on the line |
| col_i | input | 1 | Collision sensed |
| underrun_i | input | 1 | Transmit FIFO ran dry |
| frame_end_i | input | 1 | Frame finished normally |
| backoff_done_i | input | 1 | Backoff delay expired |
| crc_i | input | 32 | Running CRC of the frame |
| tx_go_o | output | 1 | Start an attempt from the frame's first byte |
| retry_o | output | 1 | Abandon this attempt and back off |
| tx_stop_o | output | 1 | Frame terminated, no retry |
| force_en_o | output | 1 | Serial output driven by `force_bit_o` |
| force_bit_o | output | 1 | Forced tail bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 event clear, 1 mask |
| reg_wdata_i | input | 3 | Write data: bit 0 underrun, bit 1 retry limit, bit 2 late collision |
| evt_o | output | 3 | Sticky event bits |
| irq_o | output | 1 | Interrupt |

## Verification
The hardest state to reach is the retry limit. Fifteen in-slot collisions, each after a different random number of bit ticks and a random backoff wait, must come first, and only then does the sixteenth collision ends the frame. The bench drives whole frames, with sparse random bit ticks, through that sequence and also through one sequence of two near-boundary collisions. The second of those would read as late if the count carried over from the first attempt. A clear write landing in the exact cycle an underrun tail ends is placed in a directed frame.

// File: rtl/tx_err_pkg.sv
package tx_err_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_BACKOFF, ST_JAM, ST_CLOSE
  } txe_state_e;

  typedef enum logic [1:0] {
    CS_OK        = 2'd0,
    CS_UNDERRUN  = 2'd1,
    CS_RETRY_LIM = 2'd2,
    CS_LATE_COL  = 2'd3
  } txe_cstat_e;

  localparam int EV_UN = 0;
  localparam int EV_RL = 1;
  localparam int EV_LC = 2;
  localparam int EV_W  = 3;
endpackage

// File: rtl/txe_slot_timer.sv
module txe_slot_timer #(
  parameter int SLOT_BITS = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  output logic late_o
);
  localparam int CNT_W = $clog2(SLOT_BITS + 1);
  localparam logic [CNT_W-1:0] SLOT = CNT_W'(SLOT_BITS);

  logic [CNT_W-1:0] cnt_q;

  assign late_o = (cnt_q >= SLOT);

  // saturates at the boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (en_i && tick_i && !late_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/txe_jam_shifter.sv
module txe_jam_shifter #(
  parameter int CRC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CRC_W-1:0] crc_i,
  input  logic             active_i,
  input  logic             tick_i,
  output logic             bit_o,
  output logic             last_o
);
  localparam int IDX_W = (CRC_W > 1) ? $clog2(CRC_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CRC_W - 1);

  logic [CRC_W-1:0] sh_q;
  logic [IDX_W-1:0] idx_q;

  assign bit_o  = sh_q[0];
  assign last_o = (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= ~crc_i;  // complement guarantees a check mismatch
      idx_q <= '0;
    end else if (active_i && tick_i) begin
      sh_q  <= sh_q >> 1;
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/txe_event_regs.sv
module txe_event_regs
  import tx_err_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EV_W-1:0] set_i,
  input  logic            we_i,
  input  logic            sel_i,
  input  logic [EV_W-1:0] wdata_i,
  output logic [EV_W-1:0] evt_o,
  output logic [EV_W-1:0] mask_o,
  output logic            irq_o
);
  logic [EV_W-1:0] evt_q, mask_q, clr;

  assign clr    = (we_i && !sel_i) ? wdata_i : '0;
  assign evt_o  = evt_q;
  assign mask_o = mask_q;
  assign irq_o  = |(evt_q & mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q <= (evt_q & ~clr) | set_i;  // set beats clear
      if (we_i && sel_i) mask_q <= wdata_i;
    end
  end
endmodule

// File: rtl/txe_frame_fsm.sv
module txe_frame_fsm
  import tx_err_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            desc_valid_i,
  input  logic            desc_last_i,
  input  logic            col_i,
  input  logic            underrun_i,
  input  logic            frame_end_i,
  input  logic            backoff_done_i,
  input  logic            bit_tick_i,
  input  logic            late_i,
  input  logic            jam_last_i,
  output txe_state_e      state_o,
  output logic            tx_go_o,
  output logic            retry_o,
  output logic            tx_stop_o,
  output logic            desc_done_o,
  output logic [1:0]      desc_stat_o,
  output logic            jam_load_o,
  output logic            timer_clr_o,
  output logic [EV_W-1:0] ev_set_o
);
  localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);
  localparam logic [ATT_W-1:0] LAST_ATT = ATT_W'(MAX_ATTEMPTS - 1);

  txe_state_e       st_q, st_d;
  txe_cstat_e       stat_q, stat_d;
  logic [ATT_W-1:0] att_q, att_d;

  assign state_o     = st_q;
  assign desc_stat_o = stat_q;

  always_comb begin
    st_d        = st_q;
    stat_d      = stat_q;
    att_d       = att_q;
    tx_go_o     = 1'b0;
    retry_o     = 1'b0;
    tx_stop_o   = 1'b0;
    desc_done_o = 1'b0;
    jam_load_o  = 1'b0;
    timer_clr_o = 1'b0;
    ev_set_o    = '0;
    unique case (st_q)
      ST_IDLE: if (desc_valid_i) begin
        tx_go_o     = 1'b1;
        timer_clr_o = 1'b1;
        att_d       = '0;
        st_d        = ST_SEND;
      end
      ST_SEND: begin
        if (col_i) begin
          if (late_i) begin
            tx_stop_o       = 1'b1;
            ev_set_o[EV_LC] = 1'b1;
            stat_d          = CS_LATE_COL;
            st_d            = ST_CLOSE;
          end else if (att_q == LAST_ATT) begin
            tx_stop_o       = 1'b1;
            ev_set_o[EV_RL] = 1'b1;
            stat_d          = CS_RETRY_LIM;
            st_d            = ST_CLOSE;
          end else begin
            retry_o = 1'b1;
            att_d   = att_q + 1'b1;
            st_d    = ST_BACKOFF;
          end
        end else if (underrun_i) begin
          jam_load_o = 1'b1;
          st_d       = ST_JAM;
        end else if (frame_end_i) begin
          stat_d = CS_OK;
          st_d   = ST_CLOSE;
        end
      end
      ST_BACKOFF: if (backoff_done_i) begin
        tx_go_o     = 1'b1;
        timer_clr_o = 1'b1;
        st_d        = ST_SEND;
      end
      ST_JAM: if (bit_tick_i && jam_last_i) begin
        tx_stop_o       = 1'b1;
        ev_set_o[EV_UN] = 1'b1;
        stat_d          = CS_UNDERRUN;
        st_d            = ST_CLOSE;
      end
      ST_CLOSE: if (desc_valid_i) begin
        desc_done_o = 1'b1;
        if (desc_last_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      stat_q <= CS_OK;
      att_q  <= '0;
    end else begin
      st_q   <= st_d;
      stat_q <= stat_d;
      att_q  <= att_d;
    end
  end
endmodule

// File: rtl/tx_err_ctl.sv
module tx_err_ctl
  import tx_err_pkg::*;
#(
  parameter int SLOT_BITS    = 512,
  parameter int MAX_ATTEMPTS = 16,
  parameter int CRC_W        = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             desc_valid_i,
  input  logic             desc_last_i,
  output logic             desc_done_o,
  output logic [1:0]       desc_stat_o,
  input  logic             bit_tick_i,
  input  logic             col_i,
  input  logic             underrun_i,
  input  logic             frame_end_i,
  input  logic             backoff_done_i,
  input  logic [CRC_W-1:0] crc_i,
  output logic             tx_go_o,
  output logic             retry_o,
  output logic             tx_stop_o,
  output logic             force_en_o,
  output logic             force_bit_o,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [EV_W-1:0]  reg_wdata_i,
  output logic [EV_W-1:0]  evt_o,
  output logic             irq_o
);
  txe_state_e      st;
  logic            late, jam_last, jam_load, timer_clr;
  logic [EV_W-1:0] ev_set, mask_w;

  txe_frame_fsm #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_fsm (
    .clk_i, .rst_ni, .desc_valid_i, .desc_last_i, .col_i, .underrun_i,
    .frame_end_i, .backoff_done_i, .bit_tick_i,
    .late_i      (late),
    .jam_last_i  (jam_last),
    .state_o     (st),
    .tx_go_o, .retry_o, .tx_stop_o, .desc_done_o, .desc_stat_o,
    .jam_load_o  (jam_load),
    .timer_clr_o (timer_clr),
    .ev_set_o    (ev_set)
  );

  txe_slot_timer #(.SLOT_BITS(SLOT_BITS)) u_slot (
    .clk_i, .rst_ni,
    .clr_i  (timer_clr),
    .en_i   (st == ST_SEND),
    .tick_i (bit_tick_i),
    .late_o (late)
  );

  assign force_en_o = (st == ST_JAM);

  txe_jam_shifter #(.CRC_W(CRC_W)) u_jam (
    .clk_i, .rst_ni,
    .load_i   (jam_load),
    .crc_i,
    .active_i (force_en_o),
    .tick_i   (bit_tick_i),
    .bit_o    (force_bit_o),
    .last_o   (jam_last)
  );

  txe_event_regs u_evt (
    .clk_i, .rst_ni,
    .set_i   (ev_set),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .evt_o,
    .mask_o  (mask_w),
    .irq_o
  );
endmodule

// File: rtl/tx_err_ctl_chk.sv
module tx_err_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       desc_valid_i,
  input logic       desc_last_i,
  input logic       desc_done_o,
  input logic       tx_go_o,
  input logic       retry_o,
  input logic       tx_stop_o,
  input logic       force_en_o,
  input logic       reg_we_i,
  input logic       reg_sel_i,
  input logic [2:0] mask_w,
  input logic [2:0] evt_o,
  input logic       irq_o
);
  a_r11_irq_tracks_masked_events: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(evt_o & mask_w));

  a_r2_close_needs_descriptor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_done_o |-> desc_valid_i);

  a_r5_retry_never_with_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(retry_o && tx_stop_o));

  a_r4_underrun_event_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o[0]) |-> $past(tx_stop_o));

  a_r7_late_event_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o[2]) |-> $past(tx_stop_o));

  a_r3_tail_excludes_close_and_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_en_o |-> (!desc_done_o && !tx_go_o));

  a_r9_single_frame_close_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_done_o && desc_last_i) |=> !desc_done_o);

  a_r10_clear_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(evt_o) & ~evt_o)) |-> $past(reg_we_i && !reg_sel_i));
endmodule

bind tx_err_ctl tx_err_ctl_chk u_chk (
  .clk_i, .rst_ni, .desc_valid_i, .desc_last_i, .desc_done_o, .tx_go_o,
  .retry_o, .tx_stop_o, .force_en_o, .reg_we_i, .reg_sel_i,
  .mask_w (mask_w), .evt_o, .irq_o
);

// File: tb/test_tx_err_ctl.sv
module test_tx_err_ctl;
  localparam time CLK = 4ns;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        desc_valid_i, desc_last_i, desc_done_o;
  logic [1:0]  desc_stat_o;
  logic        bit_tick_i, col_i, underrun_i, frame_end_i, backoff_done_i;
  logic [31:0] crc_i;
  logic        tx_go_o, retry_o, tx_stop_o, force_en_o, force_bit_o;
  logic        reg_we_i, reg_sel_i;
  logic [2:0]  reg_wdata_i, evt_o;
  logic        irq_o;

  int   checks = 0, fails = 0;
  logic [2:0] m_evt = '0, m_mask = '0;
  bit   race = 0;

  always #(CLK/2) clk_i = ~clk_i;

  tx_err_ctl i_tx_err_ctl (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic nxt();
    @(posedge clk_i); #1;
    bit_tick_i = 0; col_i = 0; underrun_i = 0; frame_end_i = 0;
    backoff_done_i = 0; reg_we_i = 0;
  endtask

  task automatic send_ticks(input int t);
    int c = 0;
    while (c < t) begin
      nxt();
      bit_tick_i = ($urandom % 4) != 0;
      if (bit_tick_i) c++;
    end
  endtask

  task automatic wr(input bit sel, input logic [2:0] d);
    nxt(); desc_valid_i = 0;
    reg_we_i = 1; reg_sel_i = sel; reg_wdata_i = d; #1;
    chk("R1 no start without descriptor", tx_go_o, 0);
    if (sel) m_mask = d; else m_evt &= ~d;
    nxt(); #1;
    chk("R10 event bits", evt_o, m_evt);
    chk("R11 irq", irq_o, |(m_evt & m_mask));
  endtask

  // kind: 0 normal/late end, 1 underrun, 2 collisions, 3 col+underrun same cycle
  task automatic run_frame(input int n, input int kind, input int ncol,
                           input int early_t, input bit late_end);
    int  stat = 0;
    bit  ended = 0;
    logic [31:0] crc;
    string tg;
    nxt(); desc_valid_i = 1; desc_last_i = (n == 1); #1;
    chk("R1 R9 start", tx_go_o, 1);
    if (kind == 3) begin
      send_ticks(100);
      nxt(); col_i = 1; underrun_i = 1; crc_i = $urandom; #1;
      chk("R12 collision over underrun", retry_o, 1);
      nxt(); backoff_done_i = 1; #1;
      chk("R12 no tail", force_en_o, 0);
      chk("R5 restart", tx_go_o, 1);
    end
    for (int a = 0; a < ncol && !ended; a++) begin
      send_ticks(early_t >= 0 ? early_t : int'($urandom % 512));
      nxt(); col_i = 1; #1;
      if (a < 15) begin
        chk("R5 R8 retry", retry_o, 1);
        chk("R5 no stop", tx_stop_o, 0);
        repeat ($urandom % 3) begin
          nxt(); #1; chk("R5 wait backoff", tx_go_o, 0);
        end
        nxt(); backoff_done_i = 1; #1;
        chk("R5 restart", tx_go_o, 1);
      end else begin
        chk("R6 stop", tx_stop_o, 1);
        chk("R6 no retry", retry_o, 0);
        stat = 2; m_evt[1] = 1; ended = 1;
      end
    end
    if (!ended) begin
      if (kind == 1) begin
        int i = 0;
        send_ticks($urandom % 800);
        crc = $urandom;
        nxt(); underrun_i = 1; crc_i = crc; #1;
        chk("R3 no early stop", tx_stop_o, 0);
        while (i < 32) begin
          nxt();
          col_i = $urandom % 2;
          bit_tick_i = ($urandom % 4) != 0;
          if (race && i == 31 && bit_tick_i) begin
            reg_we_i = 1; reg_sel_i = 0; reg_wdata_i = 3'b001;
          end
          #1;
          chk("R3 tail enable", force_en_o, 1);
          chk("R3 tail bit", force_bit_o, !crc[i]);
          chk("R12 collision ignored in tail", retry_o, 0);
          if (bit_tick_i) begin
            chk("R3 stop timing", tx_stop_o, i == 31);
            i++;
          end
        end
        stat = 1; m_evt[0] = 1;
      end else if (late_end) begin
        send_ticks(512 + $urandom % 100);
        nxt(); col_i = 1; #1;
        chk("R7 stop", tx_stop_o, 1);
        chk("R7 no retry", retry_o, 0);
        stat = 3; m_evt[2] = 1;
      end else begin
        send_ticks($urandom % 700);
        nxt(); frame_end_i = 1; #1;
        chk("R2 no stop on normal end", tx_stop_o, 0);
        stat = 0;
      end
    end
    tg = stat == 0 ? "R2" : stat == 1 ? "R4" : stat == 2 ? "R6" : "R7";
    for (int i = 0; i < n; i++) begin
      nxt(); desc_valid_i = 1; desc_last_i = (i == n - 1); #1;
      chk({tg, " close"}, desc_done_o, 1);
      chk({tg, " status"}, desc_stat_o, stat);
      if (i == 0) chk("R10 event bits", evt_o, m_evt);
    end
  endtask

  initial begin
    #(CLK * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1ce5_0a17));
    rst_ni = 0; desc_valid_i = 0; desc_last_i = 0; bit_tick_i = 0; col_i = 0;
    underrun_i = 0; frame_end_i = 0; backoff_done_i = 0; crc_i = '0;
    reg_we_i = 0; reg_sel_i = 0; reg_wdata_i = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1; #1;
    chk("R10 reset events", evt_o, 0);
    chk("R11 reset irq", irq_o, 0);
    chk("R1 reset no start", tx_go_o, 0);
    chk("R2 reset no close", desc_done_o, 0);
    chk("R3 reset no tail", force_en_o, 0);

    wr(1, 3'b010);                 // R11: only retry-limit unmasked
    run_frame(3, 0, 0, -1, 0);     // R2 normal
    race = 1;
    run_frame(2, 1, 0, -1, 0);     // R3 R4, R9 back-to-back, R10 set wins
    race = 0;
    wr(0, 3'b000);
    chk("R11 masked event no irq", irq_o, 0);
    wr(1, 3'b011);
    wr(0, 3'b001);                 // R10 clear
    run_frame(1, 2, 2, 500, 0);    // R8 two near-boundary collisions
    run_frame(1, 3, 0, -1, 0);     // R12 priority
    run_frame(2, 2, 16, -1, 0);    // R6 retry limit
    wr(1, 3'b100);
    run_frame(2, 2, 3, -1, 1);     // R7 late after retries
    wr(0, 3'b111);

    for (int f = 0; f < 40; f++) begin
      int r = $urandom % 10;
      int n = 1 + $urandom % 4;
      if (r < 4)       run_frame(n, 0, 0, -1, r == 3);
      else if (r < 6)  run_frame(n, 1, 0, -1, 0);
      else if (r < 9)  run_frame(n, 2, 1 + $urandom % 3, -1, $urandom % 2);
      else             run_frame(n, 2, ($urandom % 3 == 0) ? 16 : 0, -1, 1);
      if ($urandom % 2) wr($urandom % 2, 3'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule